// File: doc/BRIEF.md
# Three-Master Fixed-Priority Bus Arbiter with Transfer Lock

This block decides which of three masters may drive a shared bus. Each master raises its own request line. The arbiter answers with a registered, one-hot grant vector. Master 0 always has the highest priority and master 2 the lowest. A busy input from the bus shows that a transfer is running. While busy is high the grant is frozen, so a running transaction is never pre-empted, even when a more important master starts asking.

While busy is low the arbiter re-decides on every rising clock edge among the requests present at that edge. If the current holder has withdrawn its request, the bus is released and handed on at that same edge. If nobody asks, every grant line goes low. A granted master is expected to assert busy within one cycle of seeing its grant. From then on the grant stays put until busy drops.

Top module: `busy_lock_arbiter`

## Requirements
- R1: A synchronous active-high `rst` seen at a rising edge makes `gnt` all zeros after that edge.
- R2: At most one bit of `gnt` is ever high.
- R3: When `busy` is low at a rising edge, `gnt` after that edge has exactly bit i set, where i is the lowest index with `req[i]` high (bit 0 = master 0 = highest priority).
- R4: When `busy` is low and `req` is all zeros at a rising edge, `gnt` becomes all zeros.
- R5: When `busy` is high at a rising edge, `gnt` keeps its previous value whatever `req` shows.
- R6: A higher-priority request raised while `busy` is high does not take the grant. The grant moves to it at the first edge where `busy` is low.
- R7: When `busy` is low and the holder has dropped its request, the grant is released at that edge and given to the highest-priority remaining requester, if there is one.
- R8: When `busy` is low at an edge, no grant bit is set afterwards for a master whose request was low at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 3 | Request lines, bit i for master i |
| busy | input | 1 | High while a bus transfer is in progress |
| gnt | output | 3 | Registered one-hot grant, bit i for master i |

## Verification
The bench raises a request from master 0 while master 2 holds a locked bus. An arbiter that ignored the lock would hand the bus over mid-transfer, and one that missed the release would keep master 2 after busy falls. It withdraws the holder's request during idle cycles to catch a design that clings to a stale grant. It also applies every request pattern with busy low, which exposes a wrong priority order, a grant given to a silent master, and more than one grant line high. Randomised runs of busy and requests are compared every cycle with a behavioural model, so slips at reset or in the hold path show up too.

// File: rtl/busy_lock_arbiter_pkg.sv
package busy_lock_arbiter_pkg;

    localparam int NUM_MASTERS = 3;
    localparam int IDX_W       = $clog2(NUM_MASTERS);

    typedef logic [NUM_MASTERS-1:0] master_vec_t;

    typedef enum logic {
        BUS_FREE   = 1'b0,
        BUS_LOCKED = 1'b1
    } bus_phase_e;

    typedef struct packed {
        master_vec_t owner;
        logic        held;
    } grant_state_t;

    function automatic bus_phase_e phase_of(input logic busy_in);
        return busy_in ? BUS_LOCKED : BUS_FREE;
    endfunction

    function automatic logic any_set(input master_vec_t v);
        return |v;
    endfunction

endpackage

// File: rtl/prio_pick.sv
module prio_pick
    import busy_lock_arbiter_pkg::*;
(
    input  master_vec_t req_in,
    output master_vec_t win_out
);
    logic [NUM_MASTERS:0] seen_lower;

    assign seen_lower[0] = 1'b0;

    for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_chain
        assign seen_lower[i+1] = seen_lower[i] | req_in[i];
        assign win_out[i]      = req_in[i] & ~seen_lower[i];
    end
endmodule

// File: rtl/grant_hold_reg.sv
module grant_hold_reg
    import busy_lock_arbiter_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  bus_phase_e   phase,
    input  master_vec_t  candidate,
    output grant_state_t state_q
);
    grant_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (phase == BUS_FREE) begin
            state_d.owner = candidate;
            state_d.held  = any_set(candidate);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/busy_lock_arbiter.sv
module busy_lock_arbiter
    import busy_lock_arbiter_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] req,
    input  logic       busy,
    output logic [2:0] gnt
);
    master_vec_t  winner;
    grant_state_t st;
    bus_phase_e   phase;

    assign phase = phase_of(busy);

    prio_pick u_pick (
        .req_in  (req),
        .win_out (winner)
    );

    grant_hold_reg u_hold (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .candidate (winner),
        .state_q   (st)
    );

    assign gnt = st.held ? st.owner : '0;
endmodule

module busy_lock_arbiter_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] req,
    input logic       busy,
    input logic [2:0] gnt
);
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (gnt == 3'b000)); // R1
    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt)); // R2
    AST_TOP_PRIORITY: assert property (@(posedge clk) disable iff (rst) (!busy && req[0]) |=> gnt[0]); // R3
    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst) (!busy && req == 3'b000) |=> (gnt == 3'b000)); // R4
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst) busy |=> $stable(gnt)); // R5
    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst) (busy && gnt[2] && req[0]) |=> !gnt[0]); // R6
    AST_ONLY_ASKERS: assert property (@(posedge clk) disable iff (rst) !busy |=> ((gnt & ~$past(req)) == 3'b000)); // R8
endmodule

bind busy_lock_arbiter busy_lock_arbiter_chk u_chk (.*);

// File: tb/test_busy_lock_arbiter.sv
module test_busy_lock_arbiter;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] req;
    logic       busy;
    logic [2:0] gnt;

    int checks = 0;
    int errors = 0;
    logic [2:0] model_gnt = 3'b000;

    always #5 clk = ~clk;

    busy_lock_arbiter i_busy_lock_arbiter (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .busy (busy),
        .gnt  (gnt)
    );

    task automatic check(input logic ok, input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: gnt=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Apply inputs at a falling edge, update the model at the rising edge,
    // compare at the following falling edge.
    task automatic step(input logic r, input logic [2:0] q, input logic b, input string tag);
        int ones;
        rst = r; req = q; busy = b;
        @(posedge clk);
        if (r) begin
            model_gnt = 3'b000;
        end else if (!b) begin
            model_gnt = 3'b000;
            for (int i = 0; i < 3; i++) begin
                if (q[i]) begin
                    model_gnt[i] = 1'b1;
                    break;
                end
            end
        end
        @(negedge clk);
        check(gnt === model_gnt, tag, gnt, model_gnt);
        ones = 0;
        for (int i = 0; i < 3; i++) if (gnt[i]) ones++;
        check(ones <= 1, "R2", gnt, model_gnt);
    endtask

    initial begin
        rst = 1'b1; req = 3'b000; busy = 1'b0;
        @(negedge clk);
        step(1, 3'b111, 0, "R1 reset");
        step(1, 3'b010, 1, "R1 reset");
        // every pattern with the bus free
        for (int p = 0; p < 8; p++) begin
            step(0, p[2:0], 0, (p == 0) ? "R4 idle empty" : "R3 priority");
            check((gnt & ~p[2:0]) == 3'b000, "R8 asker only", gnt, p[2:0]);
        end
        // R6: master 2 locks, master 0 asks mid-transfer
        step(0, 3'b100, 0, "R3 grant m2");
        step(0, 3'b100, 1, "R5 lock");
        step(0, 3'b101, 1, "R6 no preempt");
        step(0, 3'b111, 1, "R6 no preempt");
        step(0, 3'b101, 0, "R6 handover");
        check(gnt == 3'b001, "R6 m0 wins", gnt, 3'b001);
        // R7: holder drops request while idle
        step(0, 3'b010, 0, "R3 grant m1");
        step(0, 3'b100, 0, "R7 release to m2");
        step(0, 3'b000, 0, "R7 release to none");
        // R5: hold an empty grant while busy
        step(0, 3'b000, 1, "R5 hold empty");
        step(0, 3'b111, 1, "R5 hold empty");
        step(1, 3'b111, 1, "R1 reset under busy");
        // random traffic
        for (int n = 0; n < 400; n++) begin
            logic [2:0] q;
            logic b, r;
            q = 3'($urandom_range(0, 7));
            b = ($urandom_range(0, 2) == 0);
            r = ($urandom_range(0, 60) == 0);
            step(r, q, b, r ? "R1 random" : (b ? "R5 random" : "R3 random"));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: gnt=%b expected=done", gnt);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule